// File: doc/BRIEF.md
# Memory Error Event Router

The router collects six error and status events from a memory controller and steers each of them, independently, to any mix of four notification lines: a system-control interrupt (`ntf_sci`), a system-management interrupt (`ntf_smi`), a system error (`ntf_serr`) and a machine-check error (`ntf_mcerr`). Every event latches into a sticky status bit that software clears by writing 1. A notification line stays high for as long as at least one status bit is set whose enable bit is set in that line's routing register.

Three of the event inputs are bit-error reports: a demand-read uncorrectable error, a scrubber uncorrectable error and a corrected read error. These inputs also advance a saturating error counter. When the counter first rises strictly above a programmable limit, the router raises an internal threshold event. That event arms again only after software clears the counter. The severity of each event can be read from a read-only class field. In the reporting outputs, however, every event is logged as non-fatal, whatever its class.

Top module: `mem_err_router`

## Requirements
- R1: After reset, the status bits, routing registers, threshold, counter and all notification and reporting outputs are zero.
- R2: A pulse on an event input sets its status bit at the next rising edge. The status bit order is 0 poisoned write, 1 read uncorrectable, 2 scrub uncorrectable, 3 read corrected, 4 threshold, 5 test done. A set bit stays set until it is cleared.
- R3: Writing address 0 clears every status bit whose data bit is 1. If an event pulse and a clear of the same bit arrive in the same cycle, the event wins and the bit stays set.
- R4: Addresses 1, 2, 3 and 4 hold the enable masks for `ntf_sci`, `ntf_smi`, `ntf_serr` and `ntf_mcerr`, one bit per event in status bit order. Each line is high exactly when some status bit is set whose enable bit is set in that line's mask.
- R5: In each cycle, the error counter (read at address 6) grows by the number of pulses on the read uncorrectable, scrub uncorrectable and read corrected inputs. It saturates at its maximum value and never wraps. A write to address 6 zeroes it.
- R6: Address 5 holds the threshold. When the registered count is strictly greater than the threshold and the comparison is armed, status bit 4 is set at the next edge and the comparison disarms. Only a write to address 6 arms it again.
- R7: Address 7 reads the class field, two bits per event in status bit order: 2 means fatal (bits 0 to 2), 1 means correctable (bit 3), 0 means status (bits 4 and 5). The value is 0x006A. Writes to address 7 have no effect.
- R8: `rpt_nonfatal` is high whenever any status bit is set. `rpt_fatal` is never asserted, even for the uncorrectable events.
- R9: `reg_rdata` shows, without a clock delay, the register selected by `reg_addr`. Address 0 reads the status bits, and addresses 1 to 6 read back what R4 to R6 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_uc_wr | input | 1 | Poisoned data written, one-cycle pulse |
| ev_uc_rd | input | 1 | Uncorrectable demand-read error pulse |
| ev_uc_scrub | input | 1 | Uncorrectable scrubber error pulse |
| ev_c_rd | input | 1 | Corrected read error pulse |
| ev_test_done | input | 1 | Memory test finished pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| ntf_sci | output | 1 | System-control interrupt line |
| ntf_smi | output | 1 | System-management interrupt line |
| ntf_serr | output | 1 | System error line |
| ntf_mcerr | output | 1 | Machine-check error line |
| sts_vec | output | 6 | Sticky status bits |
| rpt_nonfatal | output | 1 | Non-fatal report flag |
| rpt_fatal | output | 1 | Fatal report flag |

## Verification
The hardest state to reach from the ports is a full error counter. With the default 16-bit width, saturation needs more than twenty thousand error pulses, and random stimulus never gets there, so a directed phase fires all three bit-error inputs in every cycle until the count pins at its maximum. The random phase also has to produce a clear and an event on the same status bit in the same cycle. It has to cross the threshold several times as well, so threshold writes are drawn only from small values, and the bench adds one directed case where the clear and the event coincide.

// File: rtl/mer_pkg.sv
package mer_pkg;
  localparam int NUM_EV  = 6;
  localparam int NUM_NTF = 4;

  localparam int EV_UC_WR    = 0;
  localparam int EV_UC_RD    = 1;
  localparam int EV_UC_SCRUB = 2;
  localparam int EV_C_RD     = 3;
  localparam int EV_THRESH   = 4;
  localparam int EV_TESTDONE = 5;

  localparam logic [2:0] A_STATUS = 3'd0;
  localparam logic [2:0] A_ROUTE0 = 3'd1;
  localparam logic [2:0] A_THRESH = 3'd5;
  localparam logic [2:0] A_COUNT  = 3'd6;
  localparam logic [2:0] A_CLASS  = 3'd7;

  typedef enum logic [1:0] {
    CLS_STATUS = 2'b00,
    CLS_CORR   = 2'b01,
    CLS_FATAL  = 2'b10
  } ev_class_e;

  function automatic ev_class_e class_of(int idx);
    if (idx <= EV_UC_SCRUB) return CLS_FATAL;
    else if (idx == EV_C_RD) return CLS_CORR;
    else return CLS_STATUS;
  endfunction
endpackage

// File: rtl/mer_status.sv
module mer_status #(
  parameter int NUM_EV = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_set,
  input  logic [NUM_EV-1:0] clr_mask,
  output logic [NUM_EV-1:0] st_q
);
  logic [NUM_EV-1:0] st_n;

  always_comb begin
    st_n = (st_q & ~clr_mask) | ev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_n;
  end
endmodule

// File: rtl/mer_counter.sv
module mer_counter #(
  parameter int CNT_W = 16,
  parameter int INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  input  logic             clr,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             thr_ev
);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic             armed_q, armed_n;
  logic [CNT_W-1:0] cnt_n;
  logic [CNT_W:0]   sum;

  always_comb begin
    thr_ev = armed_q && (cnt_q > thr);
    sum    = {1'b0, cnt_q} + {{(CNT_W+1-INC_W){1'b0}}, inc};
    if (clr) begin
      cnt_n   = '0;
      armed_n = 1'b1;
    end else begin
      cnt_n   = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
      armed_n = thr_ev ? 1'b0 : armed_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_n;
      armed_q <= armed_n;
    end
  end
endmodule

// File: rtl/mer_route.sv
module mer_route #(
  parameter int NUM_EV  = 6,
  parameter int NUM_NTF = 4
) (
  input  logic [NUM_EV-1:0]              st,
  input  logic [NUM_NTF-1:0][NUM_EV-1:0] en,
  output logic [NUM_NTF-1:0]             ntf
);
  for (genvar k = 0; k < NUM_NTF; k++) begin : g_line
    assign ntf[k] = |(st & en[k]);
  end
endmodule

// File: rtl/mem_err_router.sv
module mem_err_router
  import mer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_uc_wr,
  input  logic              ev_uc_rd,
  input  logic              ev_uc_scrub,
  input  logic              ev_c_rd,
  input  logic              ev_test_done,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ntf_sci,
  output logic              ntf_smi,
  output logic              ntf_serr,
  output logic              ntf_mcerr,
  output logic [5:0]        sts_vec,
  output logic              rpt_nonfatal,
  output logic              rpt_fatal
);
  localparam int CLS_W = 2 * NUM_EV;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_EV-1:0]              ev_vec, clr_mask, st_q;
  logic [NUM_NTF-1:0][NUM_EV-1:0] route_q;
  logic [NUM_NTF-1:0]             ntf_vec;
  logic [CNT_W-1:0]               thr_q, thr_n, cnt_q;
  logic                           thr_ev, cnt_clr, thr_we;
  logic [1:0]                     err_inc;
  logic [CLS_W-1:0]               cls_vec;

  assign err_inc  = {1'b0, ev_uc_rd} + {1'b0, ev_uc_scrub} + {1'b0, ev_c_rd};
  assign ev_vec   = {ev_test_done, thr_ev, ev_c_rd, ev_uc_scrub, ev_uc_rd, ev_uc_wr};
  assign clr_mask = (reg_we && reg_addr == A_STATUS) ? reg_wdata[NUM_EV-1:0] : '0;
  assign cnt_clr  = reg_we && (reg_addr == A_COUNT);
  assign thr_we   = reg_we && (reg_addr == A_THRESH);

  mer_status #(.NUM_EV(NUM_EV)) u_status (
    .clk(clk), .rst_n(rst_int_n), .ev_set(ev_vec), .clr_mask(clr_mask), .st_q(st_q)
  );

  mer_counter #(.CNT_W(CNT_W), .INC_W(2)) u_counter (
    .clk(clk), .rst_n(rst_int_n), .inc(err_inc), .clr(cnt_clr),
    .thr(thr_q), .cnt_q(cnt_q), .thr_ev(thr_ev)
  );

  mer_route #(.NUM_EV(NUM_EV), .NUM_NTF(NUM_NTF)) u_route (
    .st(st_q), .en(route_q), .ntf(ntf_vec)
  );

  // routing masks, one per notification line
  for (genvar k = 0; k < NUM_NTF; k++) begin : g_route
    logic              wr_en;
    logic [NUM_EV-1:0] mask_n;
    assign wr_en = reg_we && (reg_addr == A_ROUTE0 + 3'(k));
    always_comb mask_n = wr_en ? reg_wdata[NUM_EV-1:0] : route_q[k];
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) route_q[k] <= '0;
      else            route_q[k] <= mask_n;
    end
  end

  always_comb thr_n = thr_we ? reg_wdata[CNT_W-1:0] : thr_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) thr_q <= '0;
    else            thr_q <= thr_n;
  end

  for (genvar i = 0; i < NUM_EV; i++) begin : g_cls
    assign cls_vec[2*i +: 2] = class_of(i);
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATUS: reg_rdata[NUM_EV-1:0] = st_q;
      A_THRESH: reg_rdata[CNT_W-1:0]  = thr_q;
      A_COUNT:  reg_rdata[CNT_W-1:0]  = cnt_q;
      A_CLASS:  reg_rdata[CLS_W-1:0]  = cls_vec;
      default:  reg_rdata[NUM_EV-1:0] = route_q[reg_addr - A_ROUTE0];
    endcase
  end

  assign ntf_sci      = ntf_vec[0];
  assign ntf_smi      = ntf_vec[1];
  assign ntf_serr     = ntf_vec[2];
  assign ntf_mcerr    = ntf_vec[3];
  assign sts_vec      = st_q;
  assign rpt_nonfatal = |st_q;
  assign rpt_fatal    = 1'b0;
endmodule

// File: rtl/mer_checker.sv
module mer_checker #(
  parameter int NUM_EV = 6,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EV-1:0] st_q,
  input logic [NUM_EV-1:0] ev_vec,
  input logic [NUM_EV-1:0] clr_mask,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              cnt_clr,
  input logic              thr_ev,
  input logic [3:0]        ntf_vec
);
  // R2: a pulsed event is latched at the next edge
  p_event_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vec) |=> ((st_q & $past(ev_vec)) == $past(ev_vec)));

  // R3: a set bit only falls when software cleared it
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st_q) & ~$past(clr_mask) & ~st_q) == '0));

  // R4: no line is raised while no status bit is set
  p_quiet_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == '0) |-> (ntf_vec == 4'b0000));

  // R5: the counter never goes down except when cleared
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_clr) |-> (cnt_q >= $past(cnt_q)));

  // R6: the threshold event lasts a single cycle and lands in status bit 4
  p_thr_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    thr_ev |=> !thr_ev);
  p_thr_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    thr_ev |=> st_q[4]);
endmodule

bind mem_err_router mer_checker #(.NUM_EV(mer_pkg::NUM_EV), .CNT_W(CNT_W)) u_mer_checker (
  .clk(clk), .rst_n(rst_n), .st_q(st_q), .ev_vec(ev_vec), .clr_mask(clr_mask),
  .cnt_q(cnt_q), .cnt_clr(cnt_clr), .thr_ev(thr_ev), .ntf_vec(ntf_vec)
);

// File: tb/test_mem_err_router.sv
module test_mem_err_router;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        ev_uc_wr, ev_uc_rd, ev_uc_scrub, ev_c_rd, ev_test_done;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        ntf_sci, ntf_smi, ntf_serr, ntf_mcerr;
  logic [5:0]  sts_vec;
  logic        rpt_nonfatal, rpt_fatal;

  mem_err_router i_mem_err_router (
    .clk(clk), .rst_n(rst_n), .ev_uc_wr(ev_uc_wr), .ev_uc_rd(ev_uc_rd),
    .ev_uc_scrub(ev_uc_scrub), .ev_c_rd(ev_c_rd), .ev_test_done(ev_test_done),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ntf_sci(ntf_sci), .ntf_smi(ntf_smi), .ntf_serr(ntf_serr), .ntf_mcerr(ntf_mcerr),
    .sts_vec(sts_vec), .rpt_nonfatal(rpt_nonfatal), .rpt_fatal(rpt_fatal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;

  // reference state
  logic [5:0]  m_st;
  logic [5:0]  m_rt [4];
  logic [15:0] m_thr, m_cnt;
  logic        m_arm;

  function automatic logic [15:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: return {10'd0, m_st};
      3'd5: return m_thr;
      3'd6: return m_cnt;
      3'd7: return 16'h006A;
      default: return {10'd0, m_rt[a-1]};
    endcase
  endfunction

  function automatic logic exp_line(int k);
    return |(m_st & m_rt[k]);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(logic [2:0] a);
    chk("R2 R3 status", {10'd0, sts_vec}, {10'd0, m_st});
    chk("R4 lines", {12'd0, ntf_mcerr, ntf_serr, ntf_smi, ntf_sci},
        {12'd0, exp_line(3), exp_line(2), exp_line(1), exp_line(0)});
    chk("R8 report", {14'd0, rpt_fatal, rpt_nonfatal}, {14'd0, 1'b0, |m_st});
    chk("R9 R5 R6 R7 rdata", reg_rdata, exp_read(a));
  endtask

  // ev bits: 0 poisoned write, 1 read uc, 2 scrub uc, 3 read corrected, 4 test done
  task automatic cyc(logic [4:0] ev, logic we, logic [2:0] a, logic [15:0] d);
    logic        te;
    logic [5:0]  evv, clr;
    logic [16:0] sum;
    @(negedge clk);
    {ev_test_done, ev_c_rd, ev_uc_scrub, ev_uc_rd, ev_uc_wr} = ev;
    reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    te  = m_arm && (m_cnt > m_thr);
    evv = {ev[4], te, ev[3:0]};
    clr = (we && a == 3'd0) ? d[5:0] : 6'd0;
    m_st = (m_st & ~clr) | evv;
    if (we && a == 3'd6) begin
      m_cnt = '0; m_arm = 1'b1;
    end else begin
      sum = {1'b0, m_cnt} + 17'(ev[1]) + 17'(ev[2]) + 17'(ev[3]);
      m_cnt = (sum > 17'h0FFFF) ? 16'hFFFF : sum[15:0];
      if (te) m_arm = 1'b0;
    end
    if (we && a >= 3'd1 && a <= 3'd4) m_rt[a-1] = d[5:0];
    if (we && a == 3'd5) m_thr = d;
    #1;
    check_all(a);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    {ev_test_done, ev_c_rd, ev_uc_scrub, ev_uc_rd, ev_uc_wr} = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_st = '0; m_thr = '0; m_cnt = '0; m_arm = 1'b1;
    for (int k = 0; k < 4; k++) m_rt[k] = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 status", {10'd0, sts_vec}, 16'd0);
    chk("R1 lines", {12'd0, ntf_mcerr, ntf_serr, ntf_smi, ntf_sci}, 16'd0);
    for (int a = 0; a < 7; a++) cyc(5'd0, 1'b0, 3'(a), 16'd0);

    // R4: poisoned write routed to the system-control line only
    cyc(5'd0, 1'b1, 3'd1, 16'h0001);
    cyc(5'b00001, 1'b0, 3'd0, 16'd0);
    chk("R4 sci raised", {15'd0, ntf_sci}, 16'd1);
    chk("R4 smi stays low", {15'd0, ntf_smi}, 16'd0);
    // R3: clear and event together, event wins
    cyc(5'b00001, 1'b1, 3'd0, 16'h0001);
    chk("R3 event beats clear", {15'd0, sts_vec[0]}, 16'd1);
    cyc(5'd0, 1'b1, 3'd0, 16'h003F);
    chk("R3 cleared", {10'd0, sts_vec}, 16'd0);
    // R7: write to the class field is ignored
    cyc(5'd0, 1'b1, 3'd7, 16'hFFFF);
    chk("R7 class unchanged", reg_rdata, 16'h006A);
    // R6: threshold 2 crossed by the third corrected read
    cyc(5'd0, 1'b1, 3'd5, 16'd2);
    cyc(5'd0, 1'b1, 3'd6, 16'd0);
    for (int i = 0; i < 3; i++) cyc(5'b01000, 1'b0, 3'd6, 16'd0);
    chk("R6 not yet", {15'd0, sts_vec[4]}, 16'd0);
    cyc(5'd0, 1'b0, 3'd6, 16'd0);
    chk("R6 threshold fired", {15'd0, sts_vec[4]}, 16'd1);
    cyc(5'd0, 1'b1, 3'd0, 16'h0010);
    cyc(5'b01000, 1'b0, 3'd0, 16'd0);
    cyc(5'd0, 1'b0, 3'd0, 16'd0);
    chk("R6 no refire before clear", {15'd0, sts_vec[4]}, 16'd0);
    // R5: saturation at the counter maximum
    cyc(5'd0, 1'b1, 3'd5, 16'hFFFF);
    cyc(5'd0, 1'b1, 3'd6, 16'd0);
    for (int i = 0; i < 21900; i++) cyc(5'b01110, 1'b0, 3'd6, 16'd0);
    chk("R5 saturated", reg_rdata, 16'hFFFF);
    cyc(5'd0, 1'b1, 3'd6, 16'd0);
    chk("R5 cleared", reg_rdata, 16'd0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [4:0]  ev;
      logic        we;
      logic [2:0]  a;
      logic [15:0] d;
      for (int b = 0; b < 5; b++) ev[b] = ($urandom % 5) == 0;
      we = ($urandom % 3) == 0;
      a  = 3'($urandom % 8);
      d  = 16'($urandom);
      if (a == 3'd5) d = 16'($urandom % 12);
      if (a == 3'd6 && ($urandom % 4) != 0) we = 1'b0;
      cyc(ev, we, a, d);
    end

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule